// File: doc/BRIEF.md
# ADC Calibration and Sync Sequencer

This block is the control sequencer of a sigma-delta converter's digital back end. It handles two events. The first is a self-calibration command written into the mode field of the control register. The second is a falling edge on the asynchronous SYNC input. Both events reset the digital decimation filter. The block steers the modulator input through a node select output, chosen from the normal analog input, an internal node with the inputs shorted, and an internal reference node. It also drives the active-low data-ready flag.

A self-calibration runs in a fixed order: the shorted node first, the reference node second. It waits for one modulator tick before it raises data-ready, so that any earlier data-ready indication is withdrawn. In each phase it takes the filter output when the filter reports a settled result. The shorted-node result becomes the offset coefficient. The span between the two readings is divided into a fixed numerator by an iterative divider, and the quotient becomes the gain coefficient. Both coefficients are loaded on the same edge that pulls data-ready low. A SYNC falling edge returns the block to its known run state at once. If a calibration is in progress, that calibration is abandoned and the old coefficients are kept.

Top module: `adc_cal_seq`

## Requirements
- R1: While reset is asserted and just after it is released: drdy_no is 1, node_sel_o is 0, filt_rst_o is 0, offset_o is 0 and gain_o is 2^(NSH-DW), which is 256 at the defaults.
- R2: A write with mode_i = 3'b001 is a calibration command. On the edge that samples it, filt_rst_o goes high for one cycle and node_sel_o becomes 1 (shorted node). Code 0 is the analog input and code 2 is the reference node.
- R3: After a command, drdy_no keeps its previous value until the first cycle in which mod_tick_i is high. drdy_no is 1 from the edge that samples that tick.
- R4: settled_i pulses that come before that tick are ignored. The first settled_i after the tick captures conv_data_i as the zero reading. On the same edge filt_rst_o pulses and node_sel_o becomes 2.
- R5: The next settled_i captures the reference reading. When it is greater than the zero reading, gain_o becomes floor(2^NSH / (reference − zero)) and offset_o becomes the zero reading.
- R6: When the reference reading is less than or equal to the zero reading, gain_o becomes all ones (2^(NSH+1) − 1).
- R7: A calibration ends on a single edge that updates offset_o and gain_o, pulls drdy_no low and returns node_sel_o to 0.
- R8: Writes with any mode_i other than 3'b001 are ignored. They cause no filter reset, no node change, no data-ready change and no coefficient change.
- R9: A falling edge on sync_i passes through a two-flop synchronizer. On the third rising clock edge after the input falls, filt_rst_o pulses, drdy_no is 1 and node_sel_o is 0. A rising edge on sync_i has no effect.
- R10: A SYNC falling edge during a calibration, including the divide phase, abandons that calibration. offset_o and gain_o keep their previous values.
- R11: If a detected SYNC fall and a calibration command arrive in the same cycle, SYNC takes priority and the command is dropped.
- R12: In the run state, each settled_i pulse drives drdy_no low on the edge that samples it. This is how output updates resume after a SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Write strobe for the mode field |
| mode_i | input | 3 | Mode field value; 3'b001 requests self-calibration |
| sync_i | input | 1 | Asynchronous SYNC; a falling edge resets filter and sequencer |
| mod_tick_i | input | 1 | One-cycle pulse per modulator cycle |
| settled_i | input | 1 | One-cycle pulse when the filter has a settled result |
| conv_data_i | input | DW | Filter output sampled when settled_i is high |
| node_sel_o | output | 2 | Modulator input select: 0 analog input, 1 shorted, 2 reference |
| filt_rst_o | output | 1 | One-cycle digital filter reset |
| drdy_no | output | 1 | Data-ready flag, active low |
| offset_o | output | DW | Offset coefficient (zero-scale reading) |
| gain_o | output | NSH+1 | Gain coefficient, 2^NSH divided by the span |

## Verification
A SYNC fall reaching the sequencer and a calibration command write can land on the same clock edge, and the two want opposite node selects and opposite data-ready directions. The bench lowers sync_i, waits exactly two edges so that the synchronized fall is pending, and presents the command write in that same cycle. It then checks that the node select stays on the analog input and that data-ready is high. It also checks that a later modulator tick and settled pulse behave as in the run state and do not start a calibration. A second conflict, SYNC arriving while the divider is still iterating, is judged by holding the coefficients under watch for longer than a full divide.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [1:0] {
    NODE_AIN   = 2'd0,
    NODE_SHORT = 2'd1,
    NODE_REF   = 2'd2
  } node_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ARM,
    ST_ZERO,
    ST_FULL,
    ST_DIV
  } cal_state_e;

  localparam logic [2:0] MODE_SELF_CAL = 3'b001;
endpackage

// File: rtl/adc_cal_sync.sv
module adc_cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '1;
    else         sh <= {sh[STAGES-1:0], sync_i};
  end

  assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/adc_cal_div.sv
module adc_cal_div #(
  parameter int DW  = 16,
  parameter int NSH = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] span_i,
  output logic          done_o,
  output logic [NSH:0]  quot_o
);
  localparam int QW = NSH + 1;
  localparam int CW = $clog2(QW + 1);

  logic [CW-1:0] cnt;
  logic          busy;
  logic [DW-1:0] span_q;
  logic [DW-1:0] rem;
  logic [QW-1:0] quot;
  logic [DW:0]   trial;
  logic          ge;

  // numerator is 2^NSH: a single one in the first iteration
  assign trial = {rem, (cnt == CW'(QW))};
  assign ge    = trial >= {1'b0, span_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      busy   <= 1'b0;
      span_q <= '0;
      rem    <= '0;
      quot   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (start_i) begin
        busy   <= 1'b1;
        cnt    <= CW'(QW);
        span_q <= span_i;
        rem    <= '0;
        quot   <= '0;
      end else if (busy) begin
        rem  <= ge ? DW'(trial - {1'b0, span_q}) : trial[DW-1:0];
        quot <= {quot[QW-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quot;
endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NSH = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_we_i,
  input  logic [2:0]    mode_i,
  input  logic          sync_fall_i,
  input  logic          mod_tick_i,
  input  logic          settled_i,
  input  logic [DW-1:0] conv_data_i,
  input  logic          div_done_i,
  input  logic [NSH:0]  div_quot_i,
  output logic          div_start_o,
  output logic          div_abort_o,
  output logic [DW-1:0] div_span_o,
  output logic [1:0]    node_sel_o,
  output logic          filt_rst_o,
  output logic          drdy_no,
  output logic [DW-1:0] offset_o,
  output logic [NSH:0]  gain_o
);
  localparam int          GW       = NSH + 1;
  localparam logic [GW-1:0] GAIN_RST = GW'(1) << (NSH - DW);

  cal_state_e    state;
  node_e         node_q;
  logic [DW-1:0] zero_q;
  logic [DW-1:0] span_d;
  logic          cal_cmd;

  assign cal_cmd     = mode_we_i && (mode_i == MODE_SELF_CAL);
  assign div_abort_o = sync_fall_i | cal_cmd;
  assign span_d      = (conv_data_i > zero_q) ? conv_data_i - zero_q : '0;
  assign node_sel_o  = node_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_RUN;
      node_q      <= NODE_AIN;
      zero_q      <= '0;
      div_span_o  <= '0;
      div_start_o <= 1'b0;
      filt_rst_o  <= 1'b0;
      drdy_no     <= 1'b1;
      offset_o    <= '0;
      gain_o      <= GAIN_RST;
    end else begin
      filt_rst_o  <= 1'b0;
      div_start_o <= 1'b0;
      if (sync_fall_i) begin
        state      <= ST_RUN;
        node_q     <= NODE_AIN;
        drdy_no    <= 1'b1;
        filt_rst_o <= 1'b1;
      end else if (cal_cmd) begin
        state      <= ST_ARM;
        node_q     <= NODE_SHORT;
        filt_rst_o <= 1'b1;
      end else begin
        unique case (state)
          ST_RUN: if (settled_i) drdy_no <= 1'b0;
          ST_ARM: if (mod_tick_i) begin
            drdy_no <= 1'b1;
            state   <= ST_ZERO;
          end
          ST_ZERO: if (settled_i) begin
            zero_q     <= conv_data_i;
            node_q     <= NODE_REF;
            filt_rst_o <= 1'b1;
            state      <= ST_FULL;
          end
          ST_FULL: if (settled_i) begin
            div_span_o  <= span_d;
            div_start_o <= 1'b1;
            state       <= ST_DIV;
          end
          ST_DIV: if (div_done_i) begin
            offset_o <= zero_q;
            gain_o   <= div_quot_i;
            drdy_no  <= 1'b0;
            node_q   <= NODE_AIN;
            state    <= ST_RUN;
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int DW          = 16,
  parameter int NSH         = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_we_i,
  input  logic [2:0]    mode_i,
  input  logic          sync_i,
  input  logic          mod_tick_i,
  input  logic          settled_i,
  input  logic [DW-1:0] conv_data_i,
  output logic [1:0]    node_sel_o,
  output logic          filt_rst_o,
  output logic          drdy_no,
  output logic [DW-1:0] offset_o,
  output logic [NSH:0]  gain_o
);
  logic          sync_fall;
  logic          div_start;
  logic          div_abort;
  logic          div_done;
  logic [DW-1:0] div_span;
  logic [NSH:0]  div_quot;

  adc_cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .fall_o (sync_fall)
  );

  adc_cal_div #(.DW(DW), .NSH(NSH)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .abort_i (div_abort),
    .span_i  (div_span),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  adc_cal_ctrl #(.DW(DW), .NSH(NSH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_we_i   (mode_we_i),
    .mode_i      (mode_i),
    .sync_fall_i (sync_fall),
    .mod_tick_i  (mod_tick_i),
    .settled_i   (settled_i),
    .conv_data_i (conv_data_i),
    .div_done_i  (div_done),
    .div_quot_i  (div_quot),
    .div_start_o (div_start),
    .div_abort_o (div_abort),
    .div_span_o  (div_span),
    .node_sel_o  (node_sel_o),
    .filt_rst_o  (filt_rst_o),
    .drdy_no     (drdy_no),
    .offset_o    (offset_o),
    .gain_o      (gain_o)
  );
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk #(
  parameter int DW  = 16,
  parameter int NSH = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_we_i,
  input logic [2:0]    mode_i,
  input logic          mod_tick_i,
  input logic          sync_fall,
  input logic [1:0]    node_sel_o,
  input logic          filt_rst_o,
  input logic          drdy_no,
  input logic [DW-1:0] offset_o,
  input logic [NSH:0]  gain_o
);
  logic cmd;
  assign cmd = mode_we_i && (mode_i == 3'b001);

  AST_CMD_SHORTS_NODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd && !sync_fall |=> filt_rst_o && node_sel_o == 2'd1); // R2

  AST_DRDY_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_no) |-> $past(mod_tick_i) || $past(sync_fall)); // R3

  AST_REF_AFTER_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    node_sel_o == 2'd2 && $past(node_sel_o) != 2'd2 |-> $past(node_sel_o) == 2'd1); // R4

  AST_COEF_WITH_DRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(offset_o) || !$stable(gain_o) |-> $fell(drdy_no) && node_sel_o == 2'd0); // R7

  AST_SYNC_KNOWN_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_fall |=> filt_rst_o && drdy_no && node_sel_o == 2'd0); // R9 R11
endmodule

bind adc_cal_seq adc_cal_seq_chk #(.DW(DW), .NSH(NSH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_we_i  (mode_we_i),
  .mode_i     (mode_i),
  .mod_tick_i (mod_tick_i),
  .sync_fall  (sync_fall),
  .node_sel_o (node_sel_o),
  .filt_rst_o (filt_rst_o),
  .drdy_no    (drdy_no),
  .offset_o   (offset_o),
  .gain_o     (gain_o)
);

// File: tb/adc_cal_seq_bench.sv
module adc_cal_seq_bench;
  localparam int DW  = 16;
  localparam int NSH = 24;
  localparam int NV  = 6;
  // {zero reading, reference reading}
  localparam logic [15:0] VEC [NV][2] = '{
    '{16'd100,   16'd1100},
    '{16'd0,     16'd65535},
    '{16'd5000,  16'd5001},
    '{16'd40000, 16'd30000},
    '{16'd1234,  16'd1234},
    '{16'd0,     16'd3}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_we_i = 1'b0;
  logic [2:0]    mode_i = 3'd0;
  logic          sync_i = 1'b1;
  logic          mod_tick_i = 1'b0;
  logic          settled_i = 1'b0;
  logic [DW-1:0] conv_data_i = '0;
  logic [1:0]    node_sel_o;
  logic          filt_rst_o;
  logic          drdy_no;
  logic [DW-1:0] offset_o;
  logic [NSH:0]  gain_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;

  adc_cal_seq #(.DW(DW), .NSH(NSH)) u_adc_cal_seq (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_gain(input logic [15:0] z, input logic [15:0] r);
    if (r > z) return (32'd1 << NSH) / (32'(r) - 32'(z));
    return (32'd1 << (NSH + 1)) - 1;
  endfunction

  task automatic write_mode(input logic [2:0] m);
    mode_we_i = 1'b1; mode_i = m;
    @(negedge clk_i);
    mode_we_i = 1'b0; mode_i = 3'd0;
  endtask

  task automatic tick();
    mod_tick_i = 1'b1;
    @(negedge clk_i);
    mod_tick_i = 1'b0;
  endtask

  task automatic settle(input logic [15:0] d);
    settled_i = 1'b1; conv_data_i = d;
    @(negedge clk_i);
    settled_i = 1'b0;
  endtask

  task automatic wait_drdy_low();
    for (int k = 0; k < 100 && drdy_no !== 1'b0; k++) @(negedge clk_i);
  endtask

  task automatic sync_fall_settle();
    sync_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] off_keep;
    logic [NSH:0]  gain_keep;
    logic          drdy_before;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 drdy", 32'(drdy_no), 32'd1);
    check("R1 node", 32'(node_sel_o), 32'd0);
    check("R1 offset", 32'(offset_o), 32'd0);
    check("R1 gain", 32'(gain_o), 32'd256);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 filt_rst after release", 32'(filt_rst_o), 32'd0);
    check("R1 gain after release", 32'(gain_o), 32'd256);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      drdy_before = drdy_no;
      write_mode(3'b001);
      check("R2 filt_rst pulse", 32'(filt_rst_o), 32'd1);
      check("R2 node shorted", 32'(node_sel_o), 32'd1);
      settle(16'hBEEF);  // R4: before the tick, ignored
      check("R3 drdy held before tick", 32'(drdy_no), 32'(drdy_before));
      tick();
      check("R3 drdy high after tick", 32'(drdy_no), 32'd1);
      settle(VEC[i][0]);
      check("R4 node ref", 32'(node_sel_o), 32'd2);
      check("R4 filt_rst on switch", 32'(filt_rst_o), 32'd1);
      settle(VEC[i][1]);
      wait_drdy_low();
      check("R7 drdy low at end", 32'(drdy_no), 32'd0);
      check("R7 node input", 32'(node_sel_o), 32'd0);
      check("R4 offset is zero reading", 32'(offset_o), 32'(VEC[i][0]));
      if (VEC[i][1] > VEC[i][0]) check("R5 gain", 32'(gain_o), exp_gain(VEC[i][0], VEC[i][1]));
      else                       check("R6 gain saturates", 32'(gain_o), exp_gain(VEC[i][0], VEC[i][1]));
    end

    // R8 other modes ignored
    off_keep = offset_o; gain_keep = gain_o;
    for (int m = 0; m < 8; m++) begin
      if (m == 1) continue;
      write_mode(3'(m));
      check("R8 no filt_rst", 32'(filt_rst_o), 32'd0);
      check("R8 node unchanged", 32'(node_sel_o), 32'd0);
      tick();
      check("R8 drdy unchanged", 32'(drdy_no), 32'd0);
    end
    repeat (40) @(negedge clk_i);
    check("R8 offset unchanged", 32'(offset_o), 32'(off_keep));
    check("R8 gain unchanged", 32'(gain_o), 32'(gain_keep));

    // R9 sync fall latency, rising edge ignored
    sync_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R9 not yet", 32'(filt_rst_o), 32'd0);
    check("R9 drdy not yet", 32'(drdy_no), 32'd0);
    @(negedge clk_i);
    check("R9 filt_rst", 32'(filt_rst_o), 32'd1);
    check("R9 drdy high", 32'(drdy_no), 32'd1);
    check("R9 node input", 32'(node_sel_o), 32'd0);
    // R12 updates resume
    settle(16'd7);
    check("R12 drdy low on settled", 32'(drdy_no), 32'd0);
    sync_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      check("R9 rise ignored filt_rst", 32'(filt_rst_o), 32'd0);
    end
    check("R9 rise ignored drdy", 32'(drdy_no), 32'd0);

    // R10 sync during divide aborts
    off_keep = offset_o; gain_keep = gain_o;
    write_mode(3'b001);
    tick();
    settle(16'd10);
    settle(16'd20);
    sync_fall_settle();
    check("R10 drdy high", 32'(drdy_no), 32'd1);
    check("R10 node input", 32'(node_sel_o), 32'd0);
    sync_i = 1'b1;
    repeat (40) @(negedge clk_i);
    check("R10 offset kept", 32'(offset_o), 32'(off_keep));
    check("R10 gain kept", 32'(gain_o), 32'(gain_keep));
    check("R10 no completion", 32'(drdy_no), 32'd1);

    // R10 sync during zero phase
    write_mode(3'b001);
    tick();
    sync_fall_settle();
    sync_i = 1'b1;
    settle(16'd50);
    check("R10 abort zero phase node", 32'(node_sel_o), 32'd0);
    repeat (40) @(negedge clk_i);
    check("R10 abort zero phase gain", 32'(gain_o), 32'(gain_keep));

    // R11 coincident sync fall and command
    repeat (4) @(negedge clk_i);
    sync_i = 1'b0;
    repeat (2) @(negedge clk_i);
    write_mode(3'b001);
    check("R11 sync wins node", 32'(node_sel_o), 32'd0);
    check("R11 sync wins drdy", 32'(drdy_no), 32'd1);
    check("R11 filt_rst", 32'(filt_rst_o), 32'd1);
    sync_i = 1'b1;
    tick();
    settle(16'd99);
    check("R11 no cal started node", 32'(node_sel_o), 32'd0);
    check("R11 run state drdy", 32'(drdy_no), 32'd0);
    repeat (40) @(negedge clk_i);
    check("R11 offset kept", 32'(offset_o), 32'(off_keep));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule